// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit carries out one of four single-bit operations on an operand: test a bit, force it to one, force it to zero, or invert it. The caller presents the operand, an operation code, a bit number and a select that says whether the operand is a full 32-bit register value or one memory byte. The bit number comes from a small immediate field or from the full value of a register; a second select chooses which one.

All outputs are registered, so results appear one clock after the request. Each result carries the operand with the selected bit changed, a new zero flag and a write-back enable. The zero flag reports the selected bit as it was before the change. The write-back enable says whether the result must be stored. Register operands wrap the bit number at 32. Byte operands wrap it at 8, and their bits above the low byte pass through untouched. The unit drives no condition code other than zero, and it leaves memory sequencing to the caller.

Top module: `bitmod_unit`

## Requirements
- R1: `op_code` encodes 2'b00 test, 2'b01 set, 2'b10 clear and 2'b11 change. A request with `in_valid` high produces `out_valid` high, with its result, at the next rising clock edge.
- R2: A test returns `result` equal to `operand`, keeps `wr_en` low, and sets `z_flag` to 1 exactly when the selected bit of `operand` is 0.
- R3: A set returns `operand` with the selected bit forced to 1 and every other bit unchanged, with `wr_en` high.
- R4: A clear returns `operand` with the selected bit forced to 0 and every other bit unchanged, with `wr_en` high.
- R5: A change returns `operand` with the selected bit inverted and every other bit unchanged, with `wr_en` high.
- R6: For set, clear and change, `z_flag` is 1 exactly when the selected bit of `operand` was 0 before the change.
- R7: With `is_mem` low, the selected bit index is the chosen bit number modulo 32.
- R8: With `is_mem` high, the selected bit index is the chosen bit number modulo 8, and `result[31:8]` equals `operand[31:8]`.
- R9: With `num_is_reg` high, the bit number is `reg_num`. With it low, the bit number is `imm_num`, and `reg_num` has no effect.
- R10: While `rst_n` is low, `out_valid`, `wr_en`, `z_flag` and `result` are cleared at each clock edge.
- R11: A cycle with `in_valid` low gives `out_valid` and `wr_en` low at the next edge, and `result` and `z_flag` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_code | input | 2 | Operation select (see R1) |
| is_mem | input | 1 | 1: byte operand, 0: 32-bit register operand |
| num_is_reg | input | 1 | 1: bit number from `reg_num`, 0: from `imm_num` |
| imm_num | input | 8 | Immediate bit number |
| reg_num | input | 32 | Register-held bit number |
| operand | input | 32 | Value to test or modify |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Operand after the operation |
| z_flag | output | 1 | 1 when the selected bit was 0 before the operation |
| wr_en | output | 1 | Result must be written back |

## Verification
Every output is due exactly one rising edge after the request that caused it. The bench drives each request on a falling edge and reads the outputs on the next falling edge, half a period after the capturing edge. An idle cycle follows some requests, and the next falling edge shows that the strobes drop while the data holds. Reset is checked at the falling edge after a reset edge. The sweeps cover every operation, both operand types, both bit-number sources and bit numbers past both wrap points. The expected result and flag come from shift-and-mask arithmetic in the bench.

// File: rtl/bitmod_pkg.sv
// Shared definitions for the single-bit test/modify unit.
// Assumes a two-bit operation code whose encoding is fixed by the requirements.
package bitmod_pkg;

    typedef enum logic [1:0] {
        BOP_TEST  = 2'b00,
        BOP_SET   = 2'b01,
        BOP_CLEAR = 2'b10,
        BOP_FLIP  = 2'b11
    } bit_op_e;

endpackage

// File: rtl/bitmod_index.sv
// Selects the bit-number source, wraps the bit number for the operand type
// and produces a one-hot mask for the selected bit.
// Assumes DATA_W and BYTE_W are powers of two with BYTE_W <= DATA_W.
module bitmod_index #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int IMM_W  = 8
) (
    input  logic              is_mem,
    input  logic              num_is_reg,
    input  logic [IMM_W-1:0]  imm_num,
    input  logic [DATA_W-1:0] reg_num,
    output logic [DATA_W-1:0] bit_mask
);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int BIDX_W = $clog2(BYTE_W);

    logic [DATA_W-1:0] chosen_num;
    logic [IDX_W-1:0]  wrapped_idx;

    // Chooses the bit-number source, widening the immediate.
    always_comb begin
        chosen_num = num_is_reg ? reg_num : DATA_W'(imm_num);
    end

    // Wraps the bit number at the operand width.
    always_comb begin
        if (is_mem)
            wrapped_idx = {{(IDX_W-BIDX_W){1'b0}}, chosen_num[BIDX_W-1:0]};
        else
            wrapped_idx = chosen_num[IDX_W-1:0];
    end

    // Builds the one-hot mask for the wrapped index.
    always_comb begin
        bit_mask = DATA_W'(1) << wrapped_idx;
    end

endmodule

// File: rtl/bitmod_alu.sv
// Applies a bit operation through a one-hot mask and computes the zero flag
// from the masked bit before any change.
// Assumes bit_mask has exactly one bit set.
module bitmod_alu
    import bitmod_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  bit_op_e           op,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] bit_mask,
    output logic [DATA_W-1:0] new_value,
    output logic              zero,
    output logic              modifies
);
    // Zero flag from the old value of the selected bit.
    always_comb begin
        zero = ~|(operand & bit_mask);
    end

    // Modified operand and write-back need, per operation.
    always_comb begin
        unique case (op)
            BOP_SET:   new_value = operand | bit_mask;
            BOP_CLEAR: new_value = operand & ~bit_mask;
            BOP_FLIP:  new_value = operand ^ bit_mask;
            default:   new_value = operand;
        endcase
        modifies = (op != BOP_TEST);
    end

endmodule

// File: rtl/bitmod_unit.sv
// Single-bit test/modify unit: test, set, clear or change one bit of a
// register operand or a memory byte, with outputs registered after one clock.
// Assumes the caller handles memory access and keeps the other condition codes.
module bitmod_unit
    import bitmod_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_code,
    input  logic              is_mem,
    input  logic              num_is_reg,
    input  logic [IMM_W-1:0]  imm_num,
    input  logic [DATA_W-1:0] reg_num,
    input  logic [DATA_W-1:0] operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              z_flag,
    output logic              wr_en
);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] next_value;
    logic              next_zero;
    logic              next_mod;

    bitmod_index #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .IMM_W(IMM_W)) u_index (
        .is_mem     (is_mem),
        .num_is_reg (num_is_reg),
        .imm_num    (imm_num),
        .reg_num    (reg_num),
        .bit_mask   (mask)
    );

    bitmod_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (bit_op_e'(op_code)),
        .operand   (operand),
        .bit_mask  (mask),
        .new_value (next_value),
        .zero      (next_zero),
        .modifies  (next_mod)
    );

    // Output register: strobes follow each request, data holds when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            z_flag    <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid & next_mod;
            if (in_valid) begin
                result <= next_value;
                z_flag <= next_zero;
            end
        end
    end

endmodule

// File: rtl/bitmod_unit_chk.sv
// Property checker for bitmod_unit, attached through bind.
// Assumes the port names and encodings of the top module.
module bitmod_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op_code,
    input logic              is_mem,
    input logic [DATA_W-1:0] operand,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              z_flag,
    input logic              wr_en
);
    logic rst_seen_q;

    // Records that reset was sampled low at the last edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // Checks the cleared state half a period after a reset edge.
    always @(negedge clk) begin
        if (rst_seen_q === 1'b1)
            AST_RESET_CLEAR: assert (!out_valid && !wr_en && !z_flag && result == '0); // R10
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_TEST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b00) |=> (result == $past(operand) && !wr_en)); // R2

    AST_SET_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b01) |=> ($countones(result ^ $past(operand)) <= 1
            && (result & $past(operand)) == $past(operand))); // R3

    AST_CLR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b10) |=> ($countones(result ^ $past(operand)) <= 1
            && (result | $past(operand)) == $past(operand))); // R4

    AST_FLIP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b11) |=> $countones(result ^ $past(operand)) == 1); // R5

    AST_FLIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b11) |=>
            (z_flag == ($countones(result & ~$past(operand)) == 1))); // R6

    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_mem) |=> result[DATA_W-1:8] == $past(operand[DATA_W-1:8])); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_valid) |=> (!out_valid && !wr_en && $stable(result) && $stable(z_flag))); // R11

    AST_WR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> out_valid); // R1

endmodule

bind bitmod_unit bitmod_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .is_mem    (is_mem),
    .operand   (operand),
    .out_valid (out_valid),
    .result    (result),
    .z_flag    (z_flag),
    .wr_en     (wr_en)
);

// File: tb/sim_bitmod_unit.sv
// Self-checking sweep bench for bitmod_unit.
module sim_bitmod_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic        is_mem = 1'b0;
    logic        num_is_reg = 1'b0;
    logic [7:0]  imm_num = 8'd0;
    logic [31:0] reg_num = 32'd0;
    logic [31:0] operand = 32'd0;
    logic        out_valid;
    logic [31:0] result;
    logic        z_flag;
    logic        wr_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bitmod_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .is_mem(is_mem), .num_is_reg(num_is_reg), .imm_num(imm_num),
        .reg_num(reg_num), .operand(operand), .out_valid(out_valid),
        .result(result), .z_flag(z_flag), .wr_en(wr_en)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one request, then checks all outputs one edge later.
    task automatic run_op(input logic [1:0] op, input logic mem, input logic src_reg,
                          input logic [7:0] imm, input logic [31:0] rnum,
                          input logic [31:0] opnd, input string req);
        logic [31:0] num;
        int idx;
        logic [31:0] m;
        logic [31:0] exp_res;
        num = src_reg ? rnum : {24'd0, imm};
        idx = mem ? int'(num % 8) : int'(num % 32);
        m = 32'd1 << idx;
        case (op)
            2'b01:   exp_res = opnd | m;
            2'b10:   exp_res = opnd & ~m;
            2'b11:   exp_res = opnd ^ m;
            default: exp_res = opnd;
        endcase
        in_valid = 1'b1; op_code = op; is_mem = mem; num_is_reg = src_reg;
        imm_num = imm; reg_num = rnum; operand = opnd;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R1 valid"}, 64'(out_valid), 64'd1);
        check({req, " result"}, 64'(result), 64'(exp_res));
        check({req, " R6 z"}, 64'(z_flag), 64'((opnd & m) == 0));
        check({req, " wr_en"}, 64'(wr_en), 64'(op != 2'b00));
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R10 reset valid", 64'(out_valid), 64'd0);
        check("R10 reset wr_en", 64'(wr_en), 64'd0);
        check("R10 reset z", 64'(z_flag), 64'd0);
        check("R10 reset result", 64'(result), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R7 R8: every op, both operand types, immediates past both wraps
        for (int op = 0; op < 4; op++)
            for (int mem = 0; mem < 2; mem++)
                for (int b = 0; b < 70; b++)
                    for (int p = 0; p < 3; p++) begin
                        logic [31:0] v;
                        v = (p == 0) ? 32'h0000_0000 : (p == 1) ? 32'hFFFF_FFFF : 32'hA5C3_5A96 ^ (32'(b) * 32'h0101_0101);
                        run_op(2'(op), mem[0], 1'b0, 8'(b), 32'hDEAD_BEEF, v, "R7 R8 imm sweep");
                    end

        // R9: register-held bit numbers, including large values
        for (int op = 0; op < 4; op++)
            for (int mem = 0; mem < 2; mem++)
                for (int k = 0; k < 40; k++) begin
                    logic [31:0] rn;
                    rn = 32'h1234_5600 * 32'(k) + 32'(k * 7);
                    run_op(2'(op), mem[0], 1'b1, 8'd3, rn, 32'h0F0F_3C3C, "R9 reg number");
                end

        // R11: idle cycle keeps data, drops strobes
        run_op(2'b11, 1'b0, 1'b0, 8'd5, 32'd0, 32'h0000_0000, "R5 flip before idle");
        operand = 32'hFFFF_FFFF; op_code = 2'b01;
        @(negedge clk);
        check("R11 idle valid", 64'(out_valid), 64'd0);
        check("R11 idle wr_en", 64'(wr_en), 64'd0);
        check("R11 idle result hold", 64'(result), 64'h20);
        check("R11 idle z hold", 64'(z_flag), 64'd1);

        // R10: reset mid-run clears outputs
        run_op(2'b01, 1'b0, 1'b0, 8'd31, 32'd0, 32'd0, "R3 set before reset");
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 reset valid again", 64'(out_valid), 64'd0);
        check("R10 reset result again", 64'(result), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule